// File: doc/BRIEF.md
# Interrupt Vector Table and Pending Array

This block keeps the software-visible state behind a message-signalled interrupt function. For each implemented vector it holds a 64-bit message address, a 32-bit message payload and a control word whose lowest bit masks the vector. It also holds one pending flag per vector. Software reaches all of this through a single 4 KiB register window. The per-vector entries fill the lower half of the window. The pending flags are read from the dword at the half-page point.

An interrupt dispatcher uses two side ports. The first is a lookup port: the dispatcher presents a vector number and receives that vector's address, payload, mask and pending state one clock later. The second is a pair of set and clear strobes for pending flags. When software writes a vector's control dword, the block raises a one-cycle strobe that carries the entry index, so that the dispatcher can re-examine that vector. On reset every entry is cleared and every implemented vector comes up masked.

Top module: `msix_vector_table`

## Requirements
- R1: After reset, every address, payload and control dword reads zero, except that bit 0 of the control dword of every implemented vector reads 1. The pending dword reads zero, `mask_upd` is low and `reg_rdata` is zero.
- R2: Vector v lives at byte offset 16*v. Within the entry, +0 holds the low address, +4 the high address, +8 the payload and +12 the control word. A full-dword write to one of these offsets is returned by a later read of the same offset. Read data appears on `reg_rdata` in the cycle after the read request.
- R3: One cycle after `disp_vec` selects an implemented vector, `disp_addr` shows {high, low} address, `disp_data` shows the payload and `disp_masked` shows bit 0 of the control word.
- R4: The pending flag of vector v is bit v of the dword at offset 0x800, which is bit v mod 8 of byte v/8. `pend_set` sets the flag and `pend_clr` clears it, both effective on the next cycle. When both strobes name the same vector, set wins. `disp_pending` reports the flag of `disp_vec` one cycle later.
- R5: Only `reg_size` = 2'b10 (dword) is honoured. Byte (2'b00) and halfword (2'b01) reads return zero, and byte and halfword writes change nothing and raise no strobe.
- R6: Only the low 12 address bits are used, and address bits 1:0 are ignored.
- R7: The following offsets read zero: offsets from 16*N_VEC up to 0x7FF, and every offset at 0x800 or above other than the pending dword. Writes to any of these offsets are dropped. Writes to the pending dword are also dropped.
- R8: A dword write to the control word of an implemented vector raises `mask_upd` for exactly the next cycle, with `mask_upd_vec` equal to the vector. At all other times `mask_upd` is low and `mask_upd_vec` is zero.
- R9: A `disp_vec` of N_VEC or more gives `disp_masked` = 1, with `disp_addr`, `disp_data` and `disp_pending` all zero. Set and clear strobes naming such a vector are ignored.
- R10: `reg_rdata` changes only in the cycle after a read request. Writes and idle cycles leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_valid | input | 1 | Register access request |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_size | input | 2 | Access size: 00 byte, 01 halfword, 10 dword |
| reg_addr | input | ADDR_W | Byte address; reduced to the 4 KiB window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the request |
| pend_set | input | 1 | Set the pending flag of `pend_set_vec` |
| pend_set_vec | input | 5 | Vector to set |
| pend_clr | input | 1 | Clear the pending flag of `pend_clr_vec` |
| pend_clr_vec | input | 5 | Vector to clear |
| disp_vec | input | 5 | Vector to look up |
| disp_addr | output | 64 | Message address of the looked-up vector |
| disp_data | output | 32 | Message payload of the looked-up vector |
| disp_masked | output | 1 | Vector mask bit (1 if out of range) |
| disp_pending | output | 1 | Vector pending flag |
| mask_upd | output | 1 | One-cycle strobe after a control-word write |
| mask_upd_vec | output | 5 | Entry index carried by the strobe |

## Verification
A wrong internal state shows up in one of three places. A corrupted entry or mask bit shows on `disp_addr`, `disp_data` or `disp_masked` one cycle after the dispatcher selects that vector. It also shows on `reg_rdata` one cycle after software reads that offset. A pending flag that was lost or stuck shows on `disp_pending` and in the pending dword with the same one-cycle delay. A decode fault that lets a narrow or out-of-window write land shows on the next read-back of the offset it hit, or as a stray `mask_upd` pulse in the very next cycle. The bench runs a behavioural model alongside the design and compares every output on every clock, so each of these faults is caught within one cycle of the access that exposes it.

// File: rtl/msix_tbl_pkg.sv
package msix_tbl_pkg;
  localparam int          OFF_W    = 12;
  localparam int          VEC_W    = 5;
  localparam int          MAX_VEC  = 32;
  localparam logic [9:0]  PBA_DW   = 10'h200;
  localparam logic [1:0]  SZ_DWORD = 2'b10;

  typedef enum logic [1:0] {
    W_ADDR_LO = 2'd0,
    W_ADDR_HI = 2'd1,
    W_DATA    = 2'd2,
    W_CTRL    = 2'd3
  } word_sel_e;
endpackage

// File: rtl/msix_tbl_decode.sv
module msix_tbl_decode
  import msix_tbl_pkg::*;
#(
  parameter int N_VEC  = 8,
  parameter int ADDR_W = 16
) (
  input  logic              valid,
  input  logic              write,
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] addr,
  output logic              tbl_we,
  output logic              rd_en,
  output logic              rd_tbl,
  output logic              rd_pba,
  output logic [VEC_W-1:0]  entry,
  output word_sel_e         word
);
  localparam logic [6:0] N_VEC_E = 7'(N_VEC);

  logic [OFF_W-1:0] off;
  logic [6:0]       entry_full;
  logic             in_tbl;
  logic             in_pba;
  logic             is_dword;

  always_comb begin
    off        = addr[OFF_W-1:0];
    entry_full = off[10:4];
    in_tbl     = !off[11] && (entry_full < N_VEC_E);
    in_pba     = (off[11:2] == PBA_DW);
    is_dword   = (size == SZ_DWORD);
    entry      = entry_full[VEC_W-1:0];
    word       = word_sel_e'(off[3:2]);
    tbl_we     = valid && write && is_dword && in_tbl;
    rd_en      = valid && !write;
    rd_tbl     = in_tbl && is_dword;
    rd_pba     = in_pba && is_dword;
  end
endmodule

// File: rtl/msix_tbl_store.sv
module msix_tbl_store
  import msix_tbl_pkg::*;
#(
  parameter int N_VEC = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [VEC_W-1:0] wr_vec,
  input  word_sel_e        wr_word,
  input  logic [31:0]      wdata,
  input  logic [VEC_W-1:0] sw_vec,
  input  word_sel_e        sw_word,
  output logic [31:0]      sw_rdata,
  input  logic [VEC_W-1:0] d_vec,
  output logic [63:0]      d_addr,
  output logic [31:0]      d_data,
  output logic             d_masked
);
  localparam int IDX_W = (N_VEC > 1) ? $clog2(N_VEC) : 1;

  logic [31:0]      lo_q  [N_VEC];
  logic [31:0]      hi_q  [N_VEC];
  logic [31:0]      dat_q [N_VEC];
  logic [31:0]      ctl_q [N_VEC];
  logic [N_VEC-1:0] mask_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int v = 0; v < N_VEC; v++) begin
        lo_q[v]  <= '0;
        hi_q[v]  <= '0;
        dat_q[v] <= '0;
        ctl_q[v] <= 32'h1;
      end
    end else if (we) begin
      case (wr_word)
        W_ADDR_LO: lo_q[wr_vec[IDX_W-1:0]]  <= wdata;
        W_ADDR_HI: hi_q[wr_vec[IDX_W-1:0]]  <= wdata;
        W_DATA:    dat_q[wr_vec[IDX_W-1:0]] <= wdata;
        default:   ctl_q[wr_vec[IDX_W-1:0]] <= wdata;
      endcase
    end
  end

  for (genvar gv = 0; gv < N_VEC; gv++) begin : g_mask
    assign mask_vec[gv] = ctl_q[gv][0];
  end

  always_comb begin
    case (sw_word)
      W_ADDR_LO: sw_rdata = lo_q[sw_vec[IDX_W-1:0]];
      W_ADDR_HI: sw_rdata = hi_q[sw_vec[IDX_W-1:0]];
      W_DATA:    sw_rdata = dat_q[sw_vec[IDX_W-1:0]];
      default:   sw_rdata = ctl_q[sw_vec[IDX_W-1:0]];
    endcase
    d_addr   = {hi_q[d_vec[IDX_W-1:0]], lo_q[d_vec[IDX_W-1:0]]};
    d_data   = dat_q[d_vec[IDX_W-1:0]];
    d_masked = mask_vec[d_vec[IDX_W-1:0]];
  end

  // R1: every implemented vector comes out of reset masked
  p_reset_masked_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (&mask_vec));

  // R2: a control-word write lands in the addressed entry
  p_ctrl_write_r2: assert property (@(posedge clk) disable iff (rst)
    (we && wr_word == W_CTRL) |=> (ctl_q[$past(wr_vec[IDX_W-1:0])] == $past(wdata)));
endmodule

// File: rtl/msix_tbl_pend.sv
module msix_tbl_pend
  import msix_tbl_pkg::*;
#(
  parameter int N_VEC = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set,
  input  logic [VEC_W-1:0] set_vec,
  input  logic             clr,
  input  logic [VEC_W-1:0] clr_vec,
  input  logic [VEC_W-1:0] q_vec,
  output logic             q_bit,
  output logic [31:0]      pend_word
);
  localparam logic [5:0] N_VEC_E = 6'(N_VEC);

  logic [N_VEC-1:0] pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
    end else begin
      for (int v = 0; v < N_VEC; v++) begin
        if (set && set_vec == VEC_W'(v))      pend_q[v] <= 1'b1;
        else if (clr && clr_vec == VEC_W'(v)) pend_q[v] <= 1'b0;
      end
    end
  end

  if (N_VEC == MAX_VEC) begin : g_full
    assign pend_word = pend_q;
  end else begin : g_part
    assign pend_word = {{(MAX_VEC-N_VEC){1'b0}}, pend_q};
  end

  assign q_bit = pend_word[q_vec];

  // R4: an in-range set is visible on the next cycle
  p_set_r4: assert property (@(posedge clk) disable iff (rst)
    (set && ({1'b0, set_vec} < N_VEC_E)) |=> pend_word[$past(set_vec)]);

  // R4: a clear without a same-vector set is visible on the next cycle
  p_clr_r4: assert property (@(posedge clk) disable iff (rst)
    (clr && !(set && set_vec == clr_vec)) |=> !pend_word[$past(clr_vec)]);
endmodule

// File: rtl/msix_vector_table.sv
module msix_vector_table
  import msix_tbl_pkg::*;
#(
  parameter int N_VEC  = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [1:0]        reg_size,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              pend_set,
  input  logic [4:0]        pend_set_vec,
  input  logic              pend_clr,
  input  logic [4:0]        pend_clr_vec,
  input  logic [4:0]        disp_vec,
  output logic [63:0]       disp_addr,
  output logic [31:0]       disp_data,
  output logic              disp_masked,
  output logic              disp_pending,
  output logic              mask_upd,
  output logic [4:0]        mask_upd_vec
);
  localparam logic [5:0] N_VEC_E = 6'(N_VEC);

  logic             tbl_we, rd_en, rd_tbl, rd_pba;
  logic [VEC_W-1:0] entry;
  word_sel_e        word;
  logic [31:0]      sw_rdata, pend_word;
  logic [63:0]      d_addr;
  logic [31:0]      d_data;
  logic             d_masked, d_pend;
  logic             disp_in_range;

  msix_tbl_decode #(.N_VEC(N_VEC), .ADDR_W(ADDR_W)) u_decode (
    .valid (reg_valid), .write (reg_write), .size (reg_size), .addr (reg_addr),
    .tbl_we (tbl_we), .rd_en (rd_en), .rd_tbl (rd_tbl), .rd_pba (rd_pba),
    .entry (entry), .word (word)
  );

  msix_tbl_store #(.N_VEC(N_VEC)) u_store (
    .clk (clk), .rst (rst),
    .we (tbl_we), .wr_vec (entry), .wr_word (word), .wdata (reg_wdata),
    .sw_vec (entry), .sw_word (word), .sw_rdata (sw_rdata),
    .d_vec (disp_vec), .d_addr (d_addr), .d_data (d_data), .d_masked (d_masked)
  );

  msix_tbl_pend #(.N_VEC(N_VEC)) u_pend (
    .clk (clk), .rst (rst),
    .set (pend_set), .set_vec (pend_set_vec),
    .clr (pend_clr), .clr_vec (pend_clr_vec),
    .q_vec (disp_vec), .q_bit (d_pend), .pend_word (pend_word)
  );

  assign disp_in_range = ({1'b0, disp_vec} < N_VEC_E);

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata    <= '0;
      disp_addr    <= '0;
      disp_data    <= '0;
      disp_masked  <= 1'b1;
      disp_pending <= 1'b0;
      mask_upd     <= 1'b0;
      mask_upd_vec <= '0;
    end else begin
      if (rd_en) begin
        if (rd_tbl)      reg_rdata <= sw_rdata;
        else if (rd_pba) reg_rdata <= pend_word;
        else             reg_rdata <= '0;
      end
      if (disp_in_range) begin
        disp_addr    <= d_addr;
        disp_data    <= d_data;
        disp_masked  <= d_masked;
        disp_pending <= d_pend;
      end else begin
        disp_addr    <= '0;
        disp_data    <= '0;
        disp_masked  <= 1'b1;
        disp_pending <= 1'b0;
      end
      mask_upd     <= tbl_we && (word == W_CTRL);
      mask_upd_vec <= (tbl_we && (word == W_CTRL)) ? entry : '0;
    end
  end

  // R5: narrow reads return zero
  p_narrow_rd_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (reg_valid && !reg_write && reg_size != SZ_DWORD) |=> (reg_rdata == '0));

  // R8: the strobe only follows a write request
  p_upd_after_write_r8: assert property (@(posedge clk) disable iff (rst)
    mask_upd |-> $past(reg_valid && reg_write && reg_size == SZ_DWORD));

  // R9: out-of-range lookups report masked and not pending
  p_disp_oob_r9: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, disp_vec} >= N_VEC_E) |=> (disp_masked && !disp_pending));

  // R10: read data holds without a read request
  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !(reg_valid && !reg_write) |=> $stable(reg_rdata));
endmodule

// File: tb/msix_vector_table_tb.sv
module msix_vector_table_tb_top;
  localparam int N = 8;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_valid = 1'b0, reg_write = 1'b0;
  logic [1:0]    reg_size = 2'b10;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          pend_set = 1'b0, pend_clr = 1'b0;
  logic [4:0]    pend_set_vec = '0, pend_clr_vec = '0, disp_vec = '0;
  logic [63:0]   disp_addr;
  logic [31:0]   disp_data;
  logic          disp_masked, disp_pending, mask_upd;
  logic [4:0]    mask_upd_vec;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  msix_vector_table #(.N_VEC(N), .ADDR_W(AW)) dut_i (
    .clk (clk), .rst (rst),
    .reg_valid (reg_valid), .reg_write (reg_write), .reg_size (reg_size),
    .reg_addr (reg_addr), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
    .pend_set (pend_set), .pend_set_vec (pend_set_vec),
    .pend_clr (pend_clr), .pend_clr_vec (pend_clr_vec),
    .disp_vec (disp_vec), .disp_addr (disp_addr), .disp_data (disp_data),
    .disp_masked (disp_masked), .disp_pending (disp_pending),
    .mask_upd (mask_upd), .mask_upd_vec (mask_upd_vec)
  );

  // behavioural reference model
  logic [31:0] m_lo [32], m_hi [32], m_dat [32], m_ctl [32];
  logic [31:0] m_pend;
  logic [31:0] e_rdata;
  logic [63:0] e_daddr;
  logic [31:0] e_ddata;
  logic        e_dmask, e_dpend, e_upd;
  logic [4:0]  e_updv;

  function automatic logic [31:0] model_read(input logic [11:0] a, input logic [1:0] sz);
    int ent;
    int wd;
    if (sz != 2'b10) return 32'h0;
    ent = int'(a[10:4]);
    wd  = int'(a[3:2]);
    if (!a[11] && ent < N) begin
      case (wd)
        0: return m_lo[ent];
        1: return m_hi[ent];
        2: return m_dat[ent];
        default: return m_ctl[ent];
      endcase
    end
    if (a[11:2] == 10'h200) return m_pend;
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int v = 0; v < 32; v++) begin
        m_lo[v] = 0; m_hi[v] = 0; m_dat[v] = 0;
        m_ctl[v] = (v < N) ? 32'h1 : 32'h0;
      end
      m_pend = 0; e_rdata = 0; e_daddr = 0; e_ddata = 0;
      e_dmask = 1; e_dpend = 0; e_upd = 0; e_updv = 0;
    end else begin
      int dv;
      int ent;
      int wd;
      if (reg_valid && !reg_write) e_rdata = model_read(reg_addr[11:0], reg_size);
      dv = int'(disp_vec);
      if (dv < N) begin
        e_daddr = {m_hi[dv], m_lo[dv]}; e_ddata = m_dat[dv];
        e_dmask = m_ctl[dv][0]; e_dpend = m_pend[dv];
      end else begin
        e_daddr = 0; e_ddata = 0; e_dmask = 1; e_dpend = 0;
      end
      e_upd = 0; e_updv = 0;
      ent = int'(reg_addr[10:4]);
      wd  = int'(reg_addr[3:2]);
      if (reg_valid && reg_write && reg_size == 2'b10 && !reg_addr[11] && ent < N) begin
        case (wd)
          0: m_lo[ent] = reg_wdata;
          1: m_hi[ent] = reg_wdata;
          2: m_dat[ent] = reg_wdata;
          default: begin m_ctl[ent] = reg_wdata; e_upd = 1; e_updv = 5'(ent); end
        endcase
      end
      for (int v = 0; v < N; v++) begin
        if (pend_set && int'(pend_set_vec) == v) m_pend[v] = 1'b1;
        else if (pend_clr && int'(pend_clr_vec) == v) m_pend[v] = 1'b0;
      end
    end
  end

  always @(posedge clk) begin
    #2;
    if (!done) begin
      checks++;
      if (reg_rdata !== e_rdata) begin
        errors++; $display("FAIL R2 model rdata: actual %h expected %h", reg_rdata, e_rdata);
      end
      checks++;
      if (disp_addr !== e_daddr || disp_data !== e_ddata || disp_masked !== e_dmask || disp_pending !== e_dpend) begin
        errors++;
        $display("FAIL R3 model lookup: actual %h/%h/%b/%b expected %h/%h/%b/%b",
                 disp_addr, disp_data, disp_masked, disp_pending, e_daddr, e_ddata, e_dmask, e_dpend);
      end
      checks++;
      if (mask_upd !== e_upd || mask_upd_vec !== e_updv) begin
        errors++;
        $display("FAIL R8 model strobe: actual %b/%0d expected %b/%0d", mask_upd, mask_upd_vec, e_upd, e_updv);
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [1:0] sz, input logic [31:0] d,
                    output logic upd, output logic [4:0] updv);
    @(negedge clk);
    reg_valid = 1; reg_write = 1; reg_addr = a; reg_size = sz; reg_wdata = d;
    @(negedge clk);
    reg_valid = 0; reg_write = 0; reg_size = 2'b10;
    upd = mask_upd; updv = mask_upd_vec;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [1:0] sz, output logic [31:0] d);
    @(negedge clk);
    reg_valid = 1; reg_write = 0; reg_addr = a; reg_size = sz;
    @(negedge clk);
    reg_valid = 0; reg_size = 2'b10;
    d = reg_rdata;
  endtask

  task automatic pend(input logic s, input logic [4:0] sv, input logic c, input logic [4:0] cv);
    @(negedge clk);
    pend_set = s; pend_set_vec = sv; pend_clr = c; pend_clr_vec = cv;
    @(negedge clk);
    pend_set = 0; pend_clr = 0;
  endtask

  task automatic look(input logic [4:0] v);
    @(negedge clk);
    disp_vec = v;
    @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic u;
    logic [4:0] uv;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;

    // R1 reset state
    chk("R1 rdata", 64'(reg_rdata), 0);
    chk("R1 strobe", 64'(mask_upd), 0);
    rd(16'h00C, 2'b10, d); chk("R1 ctrl v0", 64'(d), 1);
    rd(16'h07C, 2'b10, d); chk("R1 ctrl v7", 64'(d), 1);
    rd(16'h074, 2'b10, d); chk("R1 addr hi v7", 64'(d), 0);
    rd(16'h800, 2'b10, d); chk("R1 pending", 64'(d), 0);

    // R2 / R8 entry writes
    wr(16'h030, 2'b10, 32'hFEE0_1000, u, uv); chk("R8 no strobe on addr", 64'(u), 0);
    wr(16'h034, 2'b10, 32'h0000_0001, u, uv);
    wr(16'h038, 2'b10, 32'h0000_4041, u, uv);
    wr(16'h03C, 2'b10, 32'h0, u, uv);
    chk("R8 strobe", 64'(u), 1); chk("R8 strobe vec", 64'(uv), 3);
    rd(16'h030, 2'b10, d); chk("R2 addr lo", 64'(d), 64'hFEE0_1000);
    rd(16'h034, 2'b10, d); chk("R2 addr hi", 64'(d), 1);
    rd(16'h038, 2'b10, d); chk("R2 data", 64'(d), 64'h4041);

    // R3 lookup
    look(5'd3);
    chk("R3 addr", disp_addr, 64'h0000_0001_FEE0_1000);
    chk("R3 data", 64'(disp_data), 64'h4041);
    chk("R3 unmasked", 64'(disp_masked), 0);
    wr(16'h03C, 2'b10, 32'h1, u, uv);
    @(negedge clk); chk("R3 remasked", 64'(disp_masked), 1);

    // R5 narrow accesses
    wr(16'h030, 2'b00, 32'hFFFF_FFFF, u, uv);
    rd(16'h030, 2'b10, d); chk("R5 byte write dropped", 64'(d), 64'hFEE0_1000);
    wr(16'h03C, 2'b01, 32'h0, u, uv); chk("R5 no strobe on half write", 64'(u), 0);
    rd(16'h030, 2'b01, d); chk("R5 half read zero", 64'(d), 0);

    // R6 aliasing
    wr(16'hA03A, 2'b10, 32'h55, u, uv);
    rd(16'h038, 2'b10, d); chk("R6 high bits folded", 64'(d), 64'h55);
    rd(16'h3039, 2'b10, d); chk("R6 low bits ignored", 64'(d), 64'h55);

    // R7 holes
    wr(16'h080, 2'b10, 32'h1234, u, uv); chk("R7 no strobe", 64'(u), 0);
    rd(16'h080, 2'b10, d); chk("R7 beyond entries", 64'(d), 0);
    rd(16'h7FC, 2'b10, d); chk("R7 top of table half", 64'(d), 0);
    wr(16'h800, 2'b10, 32'hFF, u, uv);
    rd(16'h800, 2'b10, d); chk("R7 pending write dropped", 64'(d), 0);
    rd(16'h804, 2'b10, d); chk("R7 beyond pending", 64'(d), 0);

    // R4 pending
    pend(1, 5'd5, 0, 5'd0);
    rd(16'h800, 2'b10, d); chk("R4 set v5", 64'(d), 64'h20);
    pend(1, 5'd2, 1, 5'd2);
    rd(16'h800, 2'b10, d); chk("R4 set wins", 64'(d), 64'h24);
    pend(0, 5'd0, 1, 5'd5);
    rd(16'h800, 2'b10, d); chk("R4 clear v5", 64'(d), 64'h04);
    look(5'd2);
    chk("R4 lookup pending", 64'(disp_pending), 1);
    chk("R1 v2 still masked", 64'(disp_masked), 1);

    // R9 out of range
    pend(1, 5'd9, 0, 5'd0);
    rd(16'h800, 2'b10, d); chk("R9 oob set ignored", 64'(d), 64'h04);
    look(5'd12);
    chk("R9 oob masked", 64'(disp_masked), 1);
    chk("R9 oob addr", disp_addr, 0);
    chk("R9 oob pending", 64'(disp_pending), 0);

    // R10 hold
    rd(16'h034, 2'b10, d); chk("R10 read", 64'(d), 1);
    wr(16'h034, 2'b10, 32'h7, u, uv);
    @(negedge clk); @(negedge clk);
    chk("R10 hold after write", 64'(reg_rdata), 1);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule